// File: doc/BRIEF.md
# Successive-Approximation Converter Readout Logic

This block is the digital half of a 12-bit successive-approximation converter. A rising edge on the conversion-start input puts the sampling stage into hold. A sequencer then resolves one result bit per decision period, starting from the most significant bit. It presents each trial code to the comparison network on `dac_code` and reads back a single comparator bit. When the last bit is decided, the sampling stage returns to track and the finished code becomes available.

The host has only two serial wires: a clock it drives and a data line it samples. There is no end-of-conversion flag. Finished results go into an output register. A serial read works from a private copy of that register, taken when the read starts. When a conversion finishes while a read is still under way, the new code waits until that read ends. If the read is still unfinished at the next falling edge of conversion start, the waiting code is loaded at that edge and the read is cancelled.

All inputs are treated as synchronous to `clk`. Edges of `conv_start` and `sclk` are found by comparing each input with its value one clock earlier.

Top module: `sar_readout_core`

## Requirements
- R1: After reset, `track_hold`, `sdata` and `dac_code` are all zero, and the output register holds zero, so the first read returns 0x000.
- R2: A rising edge of `conv_start` seen while idle drives `track_hold` high on the next clock. It stays high for exactly DATA_W*TICK_DIV clocks and then returns low.
- R3: Bits are resolved from the MSB down. Each trial sets the bit under test in `dac_code`. At the end of each TICK_DIV-clock period the bit is kept if `comp_in` is 1 and cleared if it is 0. With `comp_in` = (input >= `dac_code`), the result equals the input code, including 0x000 and 0xFFF.
- R4: When a conversion ends with no read in progress, the output register takes the result on the same clock edge on which `track_hold` falls. A later read returns that result.
- R5: When a conversion ends during a read, that read, full or partial, delivers the older code unchanged. The new code is loaded when the read completes.
- R6: A read starts at the first `sclk` rising edge while no read is in progress. `sdata` changes only one clock after an `sclk` rising edge and delivers DATA_W bits, MSB first. The read completes at the `sclk` falling edge that follows the last rising edge.
- R7: When a code is waiting and a falling edge of `conv_start` arrives, the waiting code is loaded on that edge. The read in progress is cancelled, `sdata` goes low, and the next read delivers the new code from its MSB.
- R8: A rising edge of `conv_start` during a conversion has no effect. Hold ends on the original schedule, and the result is unchanged.
- R9: `sdata` is low whenever no read is in progress, including right after a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Conversion start; rising edge begins a conversion, falling edge may force a waiting load |
| sclk | input | 1 | Serial clock from the host |
| comp_in | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| dac_code | output | DATA_W | Trial code presented to the comparison network |
| track_hold | output | 1 | 1 while the sampling stage is held for conversion |
| sdata | output | 1 | Serial result data, MSB first |

## Verification
The sequencer is tried with a mid-scale mixed pattern and with all-zero and all-ones inputs. Together these separate a correct keep/clear decision from a stuck or inverted comparator and from an off-by-one bit index. Reads are placed in three positions: fully after a conversion, overlapping its end, and left half-finished across a `conv_start` falling edge. These placements separate an immediate load, a deferred load and a forced load, which all give the same result when no read overlaps. A second start pulse in mid-conversion shows whether the sequencer restarts or keeps its original schedule.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Sequencer phase
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

    // Width of a counter that must reach 'limit' inclusive, never zero
    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit + 1) : 1;
    endfunction

    // Width of a counter that counts 0 .. limit-1, never zero
    function automatic int mod_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/sar_edge_sense.sv
module sar_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int TICK_DIV = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_rise,
    input  logic              comp_in,
    output logic [DATA_W-1:0] trial_code,
    output logic              holding,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int IDX_W  = mod_width(DATA_W);
    localparam int TICK_W = mod_width(TICK_DIV);
    localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] MSB_MASK = ONE << (DATA_W - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

    seq_state_e        state_q;
    logic [TICK_W-1:0] tick_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] trial_q;

    logic              tick_end;
    logic              last_bit;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] decided;

    assign tick_end = (tick_q == TICK_LAST);
    assign last_bit = (idx_q == '0);
    assign bit_mask = ONE << idx_q;
    assign decided  = comp_in ? trial_q : (trial_q & ~bit_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            tick_q  <= '0;
            idx_q   <= '0;
            trial_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_rise) begin
                        state_q <= SEQ_CONV;
                        tick_q  <= '0;
                        idx_q   <= IDX_W'(DATA_W - 1);
                        trial_q <= MSB_MASK;
                    end
                end
                default: begin
                    if (tick_end) begin
                        tick_q <= '0;
                        if (last_bit) begin
                            state_q <= SEQ_IDLE;
                            trial_q <= decided;
                        end else begin
                            trial_q <= decided | (bit_mask >> 1);
                            idx_q   <= idx_q - IDX_W'(1);
                        end
                    end else begin
                        tick_q <= tick_q + TICK_W'(1);
                    end
                end
            endcase
        end
    end

    assign trial_code = trial_q;
    assign holding    = (state_q == SEQ_CONV);
    assign done       = (state_q == SEQ_CONV) && tick_end && last_bit;
    assign result     = decided;
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sar_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cancel,
    input  logic [DATA_W-1:0] word,
    output logic              sdata,
    output logic              reading,
    output logic              read_done
);
    localparam int CNT_W = cnt_width(DATA_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

    logic              reading_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              sdata_q;

    assign read_done = reading_q && sclk_fall && (cnt_q == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            reading_q <= 1'b0;
            cnt_q     <= '0;
            shreg_q   <= '0;
            sdata_q   <= 1'b0;
        end else if (sclk_rise) begin
            if (!reading_q) begin
                reading_q <= 1'b1;
                cnt_q     <= CNT_W'(1);
                sdata_q   <= word[DATA_W-1];
                shreg_q   <= word << 1;
            end else if (cnt_q != CNT_FULL) begin
                sdata_q <= shreg_q[DATA_W-1];
                shreg_q <= shreg_q << 1;
                cnt_q   <= cnt_q + CNT_W'(1);
            end
        end else if (read_done) begin
            reading_q <= 1'b0;
            cnt_q     <= '0;
            sdata_q   <= 1'b0;
        end
    end

    assign sdata   = sdata_q;
    assign reading = reading_q;
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_code,
    input  logic              reading,
    input  logic              read_done,
    input  logic              start_fall,
    output logic              force_load,
    output logic [DATA_W-1:0] out_code,
    output logic [DATA_W-1:0] pend_code
);
    logic              pend_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] pval_q;
    logic              load_now;

    assign force_load = start_fall && pend_q;
    assign load_now   = !reading || read_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            out_q  <= '0;
            pval_q <= '0;
        end else if (conv_done) begin
            if (load_now) begin
                out_q  <= conv_code;
                pend_q <= 1'b0;
            end else begin
                pval_q <= conv_code;
                pend_q <= 1'b1;
            end
        end else if (pend_q && (read_done || force_load)) begin
            out_q  <= pval_q;
            pend_q <= 1'b0;
        end
    end

    assign out_code  = out_q;
    assign pend_code = pval_q;
endmodule

// File: rtl/sar_readout_core.sv
module sar_readout_core #(
    parameter int DATA_W   = 12,
    parameter int TICK_DIV = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              sclk,
    input  logic              comp_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              track_hold,
    output logic              sdata
);
    logic              cs_rise, cs_fall;
    logic              sk_rise, sk_fall;
    logic              seq_done;
    logic [DATA_W-1:0] seq_code;
    logic              ser_reading, ser_done;
    logic              force_load;
    logic [DATA_W-1:0] out_code;
    logic [DATA_W-1:0] pend_code;

    sar_edge_sense u_cs_edge (
        .clk(clk), .rst(rst), .sig(conv_start), .rise(cs_rise), .fall(cs_fall)
    );

    sar_edge_sense u_sk_edge (
        .clk(clk), .rst(rst), .sig(sclk), .rise(sk_rise), .fall(sk_fall)
    );

    sar_sequencer #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_seq (
        .clk(clk), .rst(rst), .start_rise(cs_rise), .comp_in(comp_in),
        .trial_code(dac_code), .holding(track_hold),
        .done(seq_done), .result(seq_code)
    );

    sar_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .conv_done(seq_done), .conv_code(seq_code),
        .reading(ser_reading), .read_done(ser_done), .start_fall(cs_fall),
        .force_load(force_load), .out_code(out_code), .pend_code(pend_code)
    );

    sar_serial_port #(.DATA_W(DATA_W)) u_ser (
        .clk(clk), .rst(rst), .sclk_rise(sk_rise), .sclk_fall(sk_fall),
        .cancel(force_load), .word(out_code),
        .sdata(sdata), .reading(ser_reading), .read_done(ser_done)
    );
endmodule

// File: rtl/sar_readout_checker.sv
module sar_readout_checker #(
    parameter int DATA_W   = 12,
    parameter int TICK_DIV = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_start,
    input logic              track_hold,
    input logic [DATA_W-1:0] dac_code,
    input logic              sdata,
    input logic              reading,
    input logic              read_done,
    input logic              force_load,
    input logic              conv_done,
    input logic [DATA_W-1:0] conv_code,
    input logic [DATA_W-1:0] out_code,
    input logic [DATA_W-1:0] pend_code
);
    localparam int HOLD_LEN = DATA_W * TICK_DIV;
    localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    int hold_cnt;

    always_ff @(posedge clk) begin
        if (rst)             hold_cnt <= 0;
        else if (track_hold) hold_cnt <= hold_cnt + 1;
        else                 hold_cnt <= 0;
    end

    AST_HOLD_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(conv_start) && !track_hold) |=> track_hold); // R2

    AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        track_hold |-> (hold_cnt < HOLD_LEN)); // R2

    AST_TRIAL_MSB: assert property (@(posedge clk) disable iff (rst)
        $rose(track_hold) |-> (dac_code == TOP_BIT)); // R3

    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !reading) |=> (out_code == $past(conv_code))); // R4

    AST_DEFER_STABLE: assert property (@(posedge clk) disable iff (rst)
        (reading && !read_done && !force_load) |=> $stable(out_code)); // R5

    AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (rst)
        force_load |=> (!reading && !sdata && out_code == $past(pend_code))); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (track_hold && $rose(conv_start) && hold_cnt < HOLD_LEN - 1) |=> track_hold); // R8

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
        $fell(reading) |-> !sdata); // R9
endmodule

bind sar_readout_core sar_readout_checker #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_chk (
    .clk(clk), .rst(rst), .conv_start(conv_start), .track_hold(track_hold),
    .dac_code(dac_code), .sdata(sdata), .reading(ser_reading), .read_done(ser_done),
    .force_load(force_load), .conv_done(seq_done), .conv_code(seq_code),
    .out_code(out_code), .pend_code(pend_code)
);

// File: tb/sar_readout_core_test.sv
module sar_readout_core_test;
    localparam int DW = 12;
    localparam int TD = 25;
    localparam int CONV_CYC = DW * TD;
    localparam int WORD_MASK = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_start = 1'b0;
    logic          sclk = 1'b0;
    logic [DW-1:0] vin = '0;
    logic [DW-1:0] dac_code;
    logic          track_hold;
    logic          sdata;
    logic          comp_in;

    assign comp_in = (vin >= dac_code);

    sar_readout_core #(.DATA_W(DW), .TICK_DIV(TD)) uut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .sclk(sclk),
        .comp_in(comp_in), .dac_code(dac_code), .track_hold(track_hold), .sdata(sdata)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit m_busy, m_reading, m_pend, m_sdata, m_csq, m_sclkq;
    int m_tick, m_idx, m_trial, m_out, m_pval, m_cnt, m_shreg;

    always @(posedge clk) begin : ref_model
        bit csr, csf, sr, sf, cend, rdone, frc, rd_pre;
        int fin, dec, msk;
        if (rst) begin
            m_busy = 0; m_reading = 0; m_pend = 0; m_sdata = 0; m_csq = 0; m_sclkq = 0;
            m_tick = 0; m_idx = 0; m_trial = 0; m_out = 0; m_pval = 0; m_cnt = 0; m_shreg = 0;
        end else begin
            csr = conv_start && !m_csq;
            csf = !conv_start && m_csq;
            sr  = sclk && !m_sclkq;
            sf  = !sclk && m_sclkq;
            cend = 0; fin = 0;
            if (m_busy) begin
                if (m_tick == TD - 1) begin
                    m_tick = 0;
                    msk = 1 << m_idx;
                    dec = (int'(vin) >= m_trial) ? m_trial : (m_trial & ~msk);
                    if (m_idx == 0) begin
                        m_busy = 0; m_trial = dec; cend = 1; fin = dec;
                    end else begin
                        m_trial = dec | (msk >> 1); m_idx--;
                    end
                end else m_tick++;
            end else if (csr) begin
                m_busy = 1; m_tick = 0; m_idx = DW - 1; m_trial = 1 << (DW - 1);
            end
            rd_pre = m_reading;
            rdone  = m_reading && sf && (m_cnt == DW);
            frc    = csf && m_pend;
            if (frc) begin
                m_reading = 0; m_cnt = 0; m_sdata = 0; m_shreg = 0;
            end else if (sr) begin
                if (!m_reading) begin
                    m_reading = 1; m_cnt = 1;
                    m_sdata = ((m_out >> (DW - 1)) & 1) != 0;
                    m_shreg = (m_out << 1) & WORD_MASK;
                end else if (m_cnt != DW) begin
                    m_sdata = ((m_shreg >> (DW - 1)) & 1) != 0;
                    m_shreg = (m_shreg << 1) & WORD_MASK;
                    m_cnt++;
                end
            end else if (rdone) begin
                m_reading = 0; m_cnt = 0; m_sdata = 0;
            end
            if (cend) begin
                if (!rd_pre || rdone) begin m_out = fin; m_pend = 0; end
                else begin m_pval = fin; m_pend = 1; end
            end else if (m_pend && (rdone || frc)) begin
                m_out = m_pval; m_pend = 0;
            end
            m_csq = conv_start; m_sclkq = sclk;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(track_hold == m_busy, "R2", "track_hold vs model", int'(track_hold), int'(m_busy));
            check(int'(dac_code) == m_trial, "R3", "dac_code vs model", int'(dac_code), m_trial);
            check(sdata == m_sdata, "R6", "sdata vs model", int'(sdata), int'(m_sdata));
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_conv(input logic [DW-1:0] v, input bit keep_high);
        @(negedge clk);
        vin = v;
        conv_start = 1'b1;
        if (!keep_high) begin
            tick(3);
            conv_start = 1'b0;
        end
    endtask

    task automatic read_word(input int nbits, output logic [DW-1:0] w);
        w = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); sclk = 1'b1;
            @(negedge clk); w = {w[DW-2:0], sdata}; sclk = 1'b0;
        end
        @(negedge clk);
    endtask

    logic [DW-1:0] w;

    initial begin
        tick(5);
        rst = 1'b0;
        @(negedge clk);
        check(track_hold == 1'b0, "R1", "track_hold after reset", int'(track_hold), 0);
        check(sdata == 1'b0, "R1", "sdata after reset", int'(sdata), 0);
        check(dac_code == '0, "R1", "dac_code after reset", int'(dac_code), 0);
        read_word(DW, w);
        check(w == '0, "R1", "first read after reset", int'(w), 0);

        // Hold timing and an ordinary conversion
        @(negedge clk); vin = 12'hA5C; conv_start = 1'b1;
        @(negedge clk);
        check(track_hold == 1'b1, "R2", "hold after start edge", int'(track_hold), 1);
        conv_start = 1'b0;
        tick(CONV_CYC - 1);
        check(track_hold == 1'b1, "R2", "hold on last conversion clock", int'(track_hold), 1);
        tick(1);
        check(track_hold == 1'b0, "R2", "hold released", int'(track_hold), 0);
        read_word(DW, w);
        check(w == 12'hA5C, "R4", "idle-loaded result read (R6 order)", int'(w), 'hA5C);
        check(sdata == 1'b0, "R9", "line low after read", int'(sdata), 0);

        // Extreme codes
        start_conv(12'hFFF, 1'b0); tick(CONV_CYC + 10);
        read_word(DW, w);
        check(w == 12'hFFF, "R3", "all-ones input", int'(w), 'hFFF);
        start_conv(12'h000, 1'b0); tick(CONV_CYC + 10);
        read_word(DW, w);
        check(w == 12'h000, "R3", "all-zero input", int'(w), 0);

        // Deferred load: read overlaps the end of conversion
        start_conv(12'h3C9, 1'b0); tick(CONV_CYC + 10);
        start_conv(12'h5A6, 1'b0); tick(CONV_CYC - 20);
        read_word(DW, w);
        check(w == 12'h3C9, "R5", "overlapping read keeps old code", int'(w), 'h3C9);
        read_word(DW, w);
        check(w == 12'h5A6, "R5", "new code after read completes", int'(w), 'h5A6);

        // Forced load on conversion-start falling edge
        start_conv(12'h7E1, 1'b1); tick(CONV_CYC - 20);
        read_word(5, w);
        check(w == (12'h5A6 >> 7), "R5", "partial read delivers old code", int'(w), 'h5A6 >> 7);
        tick(30);
        conv_start = 1'b0;
        @(negedge clk);
        check(sdata == 1'b0, "R7", "line low after forced load", int'(sdata), 0);
        read_word(DW, w);
        check(w == 12'h7E1, "R7", "read after forced load", int'(w), 'h7E1);

        // Second start pulse during a conversion
        start_conv(12'h123, 1'b0);
        tick(97); conv_start = 1'b1;
        tick(3);  conv_start = 1'b0;
        tick(CONV_CYC - 103);
        check(track_hold == 1'b1, "R8", "hold on original last clock", int'(track_hold), 1);
        tick(1);
        check(track_hold == 1'b0, "R8", "hold ends on original schedule", int'(track_hold), 0);
        read_word(DW, w);
        check(w == 12'h123, "R8", "result unaffected by extra start", int'(w), 'h123);

        tick(5);
        summary();
        $finish;
    end
endmodule